// File: doc/BRIEF.md
# SPI Slave-Select Line Controller

This block drives the slave-select lines of an SPI master. A small index picks which slave is addressed. In manual mode the addressed line follows a level that software sets. In automatic mode the line follows burst activity reported by the transfer engine.

In automatic mode the line is asserted as soon as a burst request is seen. The block then waits one SPI half-period before it tells the engine that clocking may begin. It releases the line on the edge where the engine drops its request. One polarity input decides two things at once: the level an addressed slave is driven to, and the resting level of every line that is not asserted.

The index is frozen while a burst is in progress. A new index written during a burst therefore reaches the lines only once the burst has ended.

Top module: `cs_select_ctrl`

## Requirements
- R1: While reset is held, every select line is 1 and `clk_go` is 0.
- R2: A line that is not asserted sits at the level of `act_low` (1 when `act_low`=1, 0 when `act_low`=0), one cycle after the inputs are applied.
- R3: With `manual_mode`=1, the line numbered `sel_idx` (bit `sel_idx` of `cs_lines`) is asserted exactly when `manual_level`=1, one cycle after the inputs are applied.
- R4: An asserted line is driven to the inverse of `act_low`: 0 for active-low slaves, 1 for active-high slaves.
- R5: With `manual_mode`=0, the edge that first samples `burst_active`=1 asserts the addressed line. `clk_go` rises exactly `HALF_DIV` cycles after that edge.
- R6: In automatic mode, once `clk_go` is high, the edge that samples `burst_active`=0 releases the line and lowers `clk_go` together.
- R7: A change of `sel_idx` has no effect on the lines while a burst is in progress: in automatic mode from the start of the lead until release, and in manual mode while `burst_active`=1.
- R8: At most one line is asserted at any time.
- R9: If `burst_active` falls during the lead interval, the line is released on that edge and `clk_go` never rises.
- R10: With `manual_mode`=1, `clk_go` follows `burst_active` one cycle later, with no lead interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_idx | input | IDX_W | Number of the addressed slave |
| manual_mode | input | 1 | 1: software level drives the line; 0: burst activity drives it |
| manual_level | input | 1 | In manual mode, 1 asserts the addressed line |
| act_low | input | 1 | 1: slaves are active-low and idle lines rest high; 0: the reverse |
| burst_active | input | 1 | Burst request from the transfer engine, held until after its last edge |
| clk_go | output | 1 | Tells the engine that serial clocking may start |
| cs_lines | output | NUM_CS | Slave-select lines |

## Verification
Every output is registered. Lines and `clk_go` therefore reflect the inputs that were present at the preceding rising edge, and the one exception is `clk_go` in automatic mode, which rises `HALF_DIV` edges after the line is asserted. The driver applies one input set per falling edge and queues the value due after the next rising edge. The monitor compares that value shortly after the edge, so each queued item is paired with exactly the edge that produces it. The lead interval is checked cycle by cycle, with `clk_go` expected low on each of the first `HALF_DIV`-1 edges and high on the next. The frozen-index cases change `sel_idx` inside those windows and expect the original line to remain asserted.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_LEAD = 2'd1,
        CS_RUN  = 2'd2
    } cs_phase_e;
endpackage

// File: rtl/cs_lead_timer.sv
module cs_lead_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic count_en,
    output logic expired
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_V;
        else if (count_en && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R5: the lead count never exceeds one half-period
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_V);

    // R5: a freshly loaded count is observed next cycle
    assert_load_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_V));
endmodule

// File: rtl/cs_line_decode.sv
module cs_line_decode #(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = 2
) (
    input  logic [IDX_W-1:0]  sel,
    input  logic              assert_en,
    input  logic              act_low,
    output logic [NUM_CS-1:0] lines
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic hit;
        assign hit      = assert_en && (sel == IDX_W'(i));
        assign lines[i] = act_low ^ hit;
    end
endmodule

// File: rtl/cs_select_ctrl.sv
module cs_select_ctrl
    import cs_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int HALF_DIV = 4,
    parameter int IDX_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              manual_mode,
    input  logic              manual_level,
    input  logic              act_low,
    input  logic              burst_active,
    output logic              clk_go,
    output logic [NUM_CS-1:0] cs_lines
);
    typedef struct packed {
        cs_phase_e         phase;
        logic [IDX_W-1:0]  sel;
        logic              pol;
        logic              man;
        logic              go;
        logic [NUM_CS-1:0] lines;
    } ctl_t;

    ctl_t st_d, st_q;
    logic timer_load, timer_run, timer_expired;
    logic assert_en;
    logic busy;
    logic [NUM_CS-1:0] lines_next;

    cs_lead_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .count_en (timer_run),
        .expired  (timer_expired)
    );

    cs_line_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_decode (
        .sel       (st_d.sel),
        .assert_en (assert_en),
        .act_low   (act_low),
        .lines     (lines_next)
    );

    always_comb begin
        st_d      = st_q;
        busy      = (st_q.phase != CS_IDLE) || (manual_mode && burst_active);
        st_d.sel  = busy ? st_q.sel : sel_idx;
        st_d.pol  = act_low;
        st_d.man  = manual_mode;

        unique case (st_q.phase)
            CS_IDLE: if (!manual_mode && burst_active) st_d.phase = CS_LEAD;
            CS_LEAD: begin
                if (manual_mode || !burst_active) st_d.phase = CS_IDLE;
                else if (timer_expired)           st_d.phase = CS_RUN;
            end
            CS_RUN:  if (manual_mode || !burst_active) st_d.phase = CS_IDLE;
            default: st_d.phase = CS_IDLE;
        endcase

        timer_load = (st_q.phase == CS_IDLE) && (st_d.phase == CS_LEAD);
        timer_run  = (st_q.phase == CS_LEAD);

        if (manual_mode) begin
            assert_en = manual_level;
            st_d.go   = burst_active;
        end else begin
            assert_en = (st_d.phase != CS_IDLE);
            st_d.go   = (st_d.phase == CS_RUN);
        end
        st_d.lines = lines_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= CS_IDLE;
            st_q.sel   <= '0;
            st_q.pol   <= 1'b1;
            st_q.man   <= 1'b0;
            st_q.go    <= 1'b0;
            st_q.lines <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_go   = st_q.go;
    assign cs_lines = st_q.lines;

    // R8: no more than one line differs from the resting level
    assert_one_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.lines ^ {NUM_CS{st_q.pol}}) <= 1);

    // R5: in automatic mode clocking is released only with a line asserted
    assert_go_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.go && !st_q.man) |-> (st_q.lines != {NUM_CS{st_q.pol}}));

    // R7: the index stays put while a burst sequence is under way
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != CS_IDLE) |=> (st_q.sel == $past(st_q.sel)));

    // R6: a dropped request in the run phase releases everything together
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == CS_RUN && !burst_active && !manual_mode)
        |=> (!st_q.go && st_q.lines == {NUM_CS{st_q.pol}}));

    // R9: an aborted lead never raises the go strobe
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == CS_LEAD && !burst_active && !manual_mode) |=> !st_q.go);
endmodule

// File: tb/sim_cs_select_ctrl.sv
module sim_cs_select_ctrl;
    localparam int NUM_CS   = 4;
    localparam int HALF_DIV = 4;
    localparam int IDX_W    = 2;

    typedef struct {
        logic [NUM_CS-1:0] lines;
        logic              go;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IDX_W-1:0] sel_idx = '0;
    logic manual_mode = 1'b0, manual_level = 1'b0, act_low = 1'b1, burst_active = 1'b0;
    logic clk_go;
    logic [NUM_CS-1:0] cs_lines;

    int checks = 0;
    int fails  = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    cs_select_ctrl #(.NUM_CS(NUM_CS), .HALF_DIV(HALF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .manual_mode(manual_mode),
        .manual_level(manual_level), .act_low(act_low), .burst_active(burst_active),
        .clk_go(clk_go), .cs_lines(cs_lines)
    );

    function automatic logic [NUM_CS-1:0] want(input int idx, input bit on, input bit pol);
        logic [NUM_CS-1:0] v;
        v = {NUM_CS{pol}};
        if (on) v[idx] = ~pol;
        return v;
    endfunction

    task automatic drv(input int s, input bit man, input bit lvl, input bit pol,
                       input bit bst, input logic [NUM_CS-1:0] el, input bit eg,
                       input string tag);
        exp_t e;
        @(negedge clk);
        sel_idx = IDX_W'(s); manual_mode = man; manual_level = lvl;
        act_low = pol; burst_active = bst;
        e.lines = el; e.go = eg; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cs_lines !== e.lines || clk_go !== e.go) begin
                fails++;
                $display("FAIL %s: lines=%b go=%b expected lines=%b go=%b",
                         e.tag, cs_lines, clk_go, e.lines, e.go);
            end
        end
    end

    initial begin
        fork
            begin
                #20;
                checks++;
                if (cs_lines !== 4'hF || clk_go !== 1'b0) begin
                    fails++;
                    $display("FAIL R1: lines=%b go=%b expected lines=1111 go=0", cs_lines, clk_go);
                end
                @(negedge clk); rst_n = 1'b1;

                // R2 idle levels
                drv(0, 0, 0, 1, 0, want(0, 0, 1), 0, "R2 idle high");
                drv(0, 0, 0, 0, 0, want(0, 0, 0), 0, "R2 idle low");
                // R3/R4 manual
                drv(2, 1, 1, 1, 0, want(2, 1, 1), 0, "R3 R4 manual active-low");
                drv(1, 1, 1, 0, 0, want(1, 1, 0), 0, "R3 R4 manual active-high");
                drv(1, 1, 0, 0, 0, want(1, 0, 0), 0, "R3 manual level clear");
                // R10/R7 manual burst
                drv(3, 1, 1, 1, 0, want(3, 1, 1), 0, "R3 manual line 3");
                drv(3, 1, 1, 1, 1, want(3, 1, 1), 1, "R10 manual go follows");
                drv(0, 1, 1, 1, 1, want(3, 1, 1), 1, "R7 manual index frozen");
                drv(0, 1, 1, 1, 0, want(0, 1, 1), 0, "R7 manual index after burst");
                // R5/R6/R7 automatic
                drv(1, 0, 0, 1, 0, want(1, 0, 1), 0, "R2 auto idle");
                drv(1, 0, 0, 1, 1, want(1, 1, 1), 0, "R5 auto assert");
                for (int k = 1; k < HALF_DIV; k++)
                    drv(3, 0, 0, 1, 1, want(1, 1, 1), 0, "R5 R7 lead, go low, index frozen");
                drv(3, 0, 0, 1, 1, want(1, 1, 1), 1, "R5 go after lead R8");
                drv(3, 0, 0, 1, 1, want(1, 1, 1), 1, "R5 run");
                drv(3, 0, 0, 1, 0, want(1, 0, 1), 0, "R6 release");
                drv(3, 0, 0, 1, 0, want(3, 0, 1), 0, "R6 idle after release");
                // R9 abort during lead
                drv(0, 0, 0, 1, 1, want(0, 1, 1), 0, "R9 lead start");
                drv(0, 0, 0, 1, 0, want(0, 0, 1), 0, "R9 abort release");
                for (int k = 0; k < HALF_DIV + 1; k++)
                    drv(0, 0, 0, 1, 0, want(0, 0, 1), 0, "R9 go stays low");
                // R4/R5/R6 active-high
                drv(2, 0, 0, 0, 1, want(2, 1, 0), 0, "R4 R5 active-high assert");
                for (int k = 1; k < HALF_DIV; k++)
                    drv(2, 0, 0, 0, 1, want(2, 1, 0), 0, "R5 active-high lead");
                drv(2, 0, 0, 0, 1, want(2, 1, 0), 1, "R5 active-high go");
                drv(2, 0, 0, 0, 0, want(2, 0, 0), 0, "R6 active-high release");
                @(negedge clk); @(negedge clk);
            end
            begin
                #100000;
                fails++;
                checks++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule